// File: doc/BRIEF.md
# Privileged Instruction Trap Checker

This block decides, for a small set of privileged system instructions, whether execution is permitted or must trap. The four instructions it judges are the wait-for-interrupt instruction, the supervisor address-translation fence, and the two hypervisor fences: one for guest-virtual mappings and one for guest-physical mappings. It is given the opcode select, the current privilege level, the virtualization flag, flags saying whether the supervisor and hypervisor extensions exist, and four status controls:
- timeout-wait (`tw`)
- trap-translation (`tvm`)
- virtual timeout-wait (`vtw`)
- virtual trap-translation (`vtvm`)

It returns one result: illegal-instruction trap, virtual-instruction trap, or "action". Action means a halt request for the wait instruction and a translation-flush request for the fences. The result is combinational. A registered one-cycle strobe per result kind follows each valid request, so that the pipeline stage after decode can take the decision without a long combinational path.

The precedence differs for each instruction. Illegal-instruction checks are evaluated ahead of virtual-instruction checks, except for the guest-virtual fence. For that fence the virtual check comes first.

Top module: `priv_trap_checker`

## Requirements
- R1: Encodings are as follows.
  - `result`: 0 = none, 1 = illegal, 2 = virtual, 3 = action. `result` is 0 whenever `in_valid` is low.
  - `op_sel`: 0 = wait-for-interrupt, 1 = supervisor fence, 2 = guest-virtual fence, 3 = guest-physical fence.
  - `priv`: 0 = user, 1 = supervisor, 3 = machine. Value 2 is reserved and never presented.
- R2: The wait instruction is illegal in either of these cases:
  - `tw` is set and the hart is in supervisor mode, or in user mode with `has_s` low.
  - The hart is in user mode with `has_s` high and the effective virtualization off.
- R3: A wait instruction that is not illegal gives virtual when virtualized and either in user mode or in supervisor mode with `vtw` set. In every other case it gives action, so machine mode always gives action.
- R4: The supervisor fence is illegal in user mode, or in supervisor mode with `tvm` set.
- R5: A supervisor fence that is not illegal gives virtual when `has_h` is high, the hart is virtualized and `vtvm` is set. Otherwise it gives action.
- R6: The guest-virtual fence behaves as follows:
  - It gives virtual in virtualized supervisor mode.
  - It gives action in machine mode, or in non-virtualized supervisor mode.
  - In user mode it is illegal.
- R7: The guest-physical fence is illegal in non-virtualized supervisor mode with `tvm` set. Otherwise it follows R6.
- R8: When `has_h` is low, `virt_in` has no effect and the effective virtualization is 0. Result 2 is then never produced.
- R9: One cycle after a valid request, exactly the strobe matching its result is high for one cycle. No strobe follows a cycle with `in_valid` low.
- R10: While `rst` is high, all strobes are low at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 2 | Instruction select (R1) |
| priv | input | 2 | Current privilege level (R1) |
| virt_in | input | 1 | Hart runs virtualized |
| has_s | input | 1 | Supervisor extension present |
| has_h | input | 1 | Hypervisor extension present |
| tw | input | 1 | Timeout-wait control |
| tvm | input | 1 | Trap translation-management control |
| vtw | input | 1 | Virtual timeout-wait control |
| vtvm | input | 1 | Virtual trap translation-management control |
| result | output | 2 | Combinational decision code |
| strb_illegal | output | 1 | Registered illegal-instruction strobe |
| strb_virtual | output | 1 | Registered virtual-instruction strobe |
| strb_action | output | 1 | Registered halt/flush strobe |

## Verification
The assertions assume that `priv` never carries the reserved value 2. They also assume that inputs are stable between driving and the next rising edge. The random stimulus draws privilege only from user, supervisor and machine, and it drives all inputs on the falling clock edge. The directed cases cover the corners where the precedence turns around: machine-mode waits, a fence in virtualized supervisor mode, and `virt_in` set with the hypervisor extension absent.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    localparam int CODE_W = 2;
    localparam int N_KINDS = 3;

    typedef enum logic [CODE_W-1:0] {
        RES_NONE    = 2'd0,
        RES_ILLEGAL = 2'd1,
        RES_VIRTUAL = 2'd2,
        RES_ACTION  = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        OP_WAIT   = 2'd0,
        OP_SFENCE = 2'd1,
        OP_GVFEN  = 2'd2,
        OP_GPFEN  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PL_USER  = 2'd0,
        PL_SUPER = 2'd1,
        PL_RSVD  = 2'd2,
        PL_MACH  = 2'd3
    } pl_e;

    typedef struct packed {
        pl_e  pl;
        logic virt;
        logic has_s;
        logic has_h;
        logic tw;
        logic tvm;
        logic vtw;
        logic vtvm;
    } ctx_t;

    function automatic logic is_user(input ctx_t c);
        return c.pl == PL_USER;
    endfunction

    function automatic logic is_super(input ctx_t c);
        return c.pl == PL_SUPER;
    endfunction

    function automatic logic is_mach(input ctx_t c);
        return c.pl == PL_MACH;
    endfunction

endpackage

// File: rtl/wait_rule.sv
module wait_rule
    import priv_trap_pkg::*;
(
    input  ctx_t ctx,
    output res_e res
);
    logic tw_block;
    logic user_block;
    logic guest_block;

    always_comb begin
        tw_block    = (is_super(ctx) || (!ctx.has_s && is_user(ctx))) && ctx.tw;
        user_block  = ctx.has_s && is_user(ctx) && !ctx.virt;
        guest_block = ctx.virt && (is_user(ctx) || (is_super(ctx) && ctx.vtw));
        if (tw_block || user_block) begin
            res = RES_ILLEGAL;
        end else if (guest_block) begin
            res = RES_VIRTUAL;
        end else begin
            res = RES_ACTION;
        end
    end
endmodule

// File: rtl/sfence_rule.sv
module sfence_rule
    import priv_trap_pkg::*;
(
    input  ctx_t ctx,
    output res_e res
);
    always_comb begin
        if (is_user(ctx) || (is_super(ctx) && ctx.tvm)) begin
            res = RES_ILLEGAL;
        end else if (ctx.has_h && ctx.virt && ctx.vtvm) begin
            res = RES_VIRTUAL;
        end else begin
            res = RES_ACTION;
        end
    end
endmodule

// File: rtl/hfence_rule.sv
module hfence_rule
    import priv_trap_pkg::*;
#(
    parameter bit GUEST_PHYS = 1'b0
) (
    input  ctx_t ctx,
    output res_e res
);
    res_e base_res;

    always_comb begin
        if (is_super(ctx) && ctx.virt) begin
            base_res = RES_VIRTUAL;
        end else if (is_mach(ctx) || (is_super(ctx) && !ctx.virt)) begin
            base_res = RES_ACTION;
        end else begin
            base_res = RES_ILLEGAL;
        end
    end

    generate
        if (GUEST_PHYS) begin : g_phys
            always_comb begin
                if (is_super(ctx) && !ctx.virt && ctx.tvm) begin
                    res = RES_ILLEGAL;
                end else begin
                    res = base_res;
                end
            end
        end else begin : g_virt
            assign res = base_res;
        end
    endgenerate
endmodule

// File: rtl/strobe_bank.sv
module strobe_bank
    import priv_trap_pkg::*;
#(
    parameter int KINDS = N_KINDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  res_e             res,
    output logic [KINDS-1:0] strb
);
    generate
        for (genvar k = 0; k < KINDS; k++) begin : g_kind
            always_ff @(posedge clk) begin
                if (rst) begin
                    strb[k] <= 1'b0;
                end else begin
                    strb[k] <= fire && (res == res_e'(k + 1));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/priv_trap_checker.sv
module priv_trap_checker
    import priv_trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  op_sel,
    input  logic [1:0]  priv,
    input  logic        virt_in,
    input  logic        has_s,
    input  logic        has_h,
    input  logic        tw,
    input  logic        tvm,
    input  logic        vtw,
    input  logic        vtvm,
    output logic [1:0]  result,
    output logic        strb_illegal,
    output logic        strb_virtual,
    output logic        strb_action
);
    ctx_t ctx;
    res_e r_wait, r_sfence, r_gv, r_gp, sel;
    logic [N_KINDS-1:0] strb;

    always_comb begin
        ctx.pl    = pl_e'(priv);
        ctx.virt  = virt_in && has_h;   // R8: no hypervisor, no virtualization
        ctx.has_s = has_s;
        ctx.has_h = has_h;
        ctx.tw    = tw;
        ctx.tvm   = tvm;
        ctx.vtw   = vtw;
        ctx.vtvm  = vtvm;
    end

    wait_rule   u_wait   (.ctx(ctx), .res(r_wait));
    sfence_rule u_sfence (.ctx(ctx), .res(r_sfence));
    hfence_rule #(.GUEST_PHYS(1'b0)) u_gv (.ctx(ctx), .res(r_gv));
    hfence_rule #(.GUEST_PHYS(1'b1)) u_gp (.ctx(ctx), .res(r_gp));

    always_comb begin
        if (!in_valid) begin
            sel = RES_NONE;
        end else begin
            unique case (op_e'(op_sel))
                OP_WAIT:   sel = r_wait;
                OP_SFENCE: sel = r_sfence;
                OP_GVFEN:  sel = r_gv;
                default:   sel = r_gp;
            endcase
        end
    end

    assign result = sel;

    strobe_bank #(.KINDS(N_KINDS)) u_strb (
        .clk(clk), .rst(rst), .fire(in_valid), .res(sel), .strb(strb)
    );

    assign strb_illegal = strb[0];
    assign strb_virtual = strb[1];
    assign strb_action  = strb[2];

    a_r1_idle_none: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> result == 2'd0);

    a_r3_mach_wait_acts: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'd0 && priv == 2'd3) |-> result == 2'd3);

    a_r4_user_sfence_illegal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'd1 && priv == 2'd0) |-> result == 2'd1);

    a_r6_user_gvfence_illegal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'd2 && priv == 2'd0) |-> result == 2'd1);

    a_r8_no_hyp_no_virtual: assert property (@(posedge clk) disable iff (rst)
        !has_h |-> result != 2'd2);

    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb_illegal, strb_virtual, strb_action}));

    a_r9_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (strb_illegal || strb_virtual || strb_action));

    a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(strb_illegal || strb_virtual || strb_action));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> !(strb_illegal || strb_virtual || strb_action));
endmodule

// File: tb/tb_priv_trap_checker.sv
module tb_priv_trap_checker;
    localparam int PERIOD = 10;
    localparam int N_RAND = 3000;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [1:0] op_sel, priv;
    logic virt_in, has_s, has_h, tw, tvm, vtw, vtvm;
    logic [1:0] result;
    logic strb_illegal, strb_virtual, strb_action;

    int checks = 0;
    int errors = 0;
    logic [1:0] prev_exp;
    logic prev_valid;
    string prev_tag;

    always #(PERIOD/2) clk = ~clk;

    priv_trap_checker dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .priv(priv),
        .virt_in(virt_in), .has_s(has_s), .has_h(has_h), .tw(tw), .tvm(tvm),
        .vtw(vtw), .vtvm(vtvm), .result(result), .strb_illegal(strb_illegal),
        .strb_virtual(strb_virtual), .strb_action(strb_action)
    );

    function automatic logic [1:0] model(input logic v, input logic [1:0] o,
        input logic [1:0] p, input logic vi, input logic s, input logic h,
        input logic tw_i, input logic tvm_i, input logic vtw_i, input logic vtvm_i);
        logic vt, u, su, m;
        logic [1:0] r;
        vt = vi & h;
        u = (p == 2'd0);
        su = (p == 2'd1);
        m = (p == 2'd3);
        if (!v) return 2'd0;
        case (o)
            2'd0: begin
                if (((su || (!s && u)) && tw_i) || (s && u && !vt)) r = 2'd1;
                else if (vt && (u || (su && vtw_i))) r = 2'd2;
                else r = 2'd3;
            end
            2'd1: begin
                if (u || (su && tvm_i)) r = 2'd1;
                else if (h && vt && vtvm_i) r = 2'd2;
                else r = 2'd3;
            end
            default: begin
                if (o == 2'd3 && su && !vt && tvm_i) r = 2'd1;
                else if (su && vt) r = 2'd2;
                else if (m || (su && !vt)) r = 2'd3;
                else r = 2'd1;
            end
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic v, input logic [1:0] o,
        input logic vi, input logic h, input logic [1:0] r);
        if (!v) return "R1";
        if (vi && !h) return "R8";
        case (o)
            2'd0: return (r == 2'd1) ? "R2" : "R3";
            2'd1: return (r == 2'd1) ? "R4" : "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Checks the strobes left by the previous request, then drives and checks a new one.
    task automatic apply(input logic v, input logic [1:0] o, input logic [1:0] p,
        input logic vi, input logic s, input logic h, input logic a, input logic b,
        input logic c, input logic d);
        logic [1:0] e;
        logic [2:0] es;
        @(negedge clk);
        es = prev_valid ? {prev_exp == 2'd3, prev_exp == 2'd2, prev_exp == 2'd1} : 3'b000;
        check({prev_tag, "/R9 strobe"}, {1'b0, strb_action, strb_virtual, strb_illegal},
              {1'b0, es});
        in_valid = v; op_sel = o; priv = p; virt_in = vi; has_s = s; has_h = h;
        tw = a; tvm = b; vtw = c; vtvm = d;
        #1;
        e = model(v, o, p, vi, s, h, a, b, c, d);
        prev_tag = tag_of(v, o, vi, h, e);
        check(prev_tag, {2'b00, result}, {2'b00, e});
        prev_exp = e;
        prev_valid = v;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; in_valid = 1'b1; op_sel = 2'd0; priv = 2'd3; virt_in = 1'b0;
        has_s = 1'b1; has_h = 1'b1; tw = 1'b0; tvm = 1'b0; vtw = 1'b0; vtvm = 1'b0;
        prev_valid = 1'b0; prev_exp = 2'd0; prev_tag = "R10";
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset strobes", {1'b0, strb_action, strb_virtual, strb_illegal}, 4'd0);
        rst = 1'b0;
        in_valid = 1'b0;

        // directed corners
        apply(1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R1 idle
        apply(1'b1, 2'd0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1); // R3 machine wait
        apply(1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); // R2 tw super
        apply(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0); // R2 user no S
        apply(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R3 user no S, no tw
        apply(1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R3 virt user
        apply(1'b1, 2'd0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R3 virt super vtw
        apply(1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R8 wait illegal
        apply(1'b1, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R4 tvm
        apply(1'b1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // R5 vtvm
        apply(1'b1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1); // R8 sfence acts
        apply(1'b1, 2'd2, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R6 virtual
        apply(1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R6 user
        apply(1'b1, 2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R7 tvm
        apply(1'b1, 2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0); // R7 virtual
        apply(1'b1, 2'd3, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R8 gp illegal
        apply(1'b0, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R9 no strobe next

        for (int i = 0; i < N_RAND; i++) begin
            logic [1:0] pr;
            pr = 2'($urandom_range(0, 2));
            if (pr == 2'd2) pr = 2'd3;
            apply(($urandom_range(0, 7) != 0), 2'($urandom), pr, 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom));
        end

        // R10: reset in the middle of a valid request
        @(negedge clk);
        in_valid = 1'b1; op_sel = 2'd0; priv = 2'd3; rst = 1'b1;
        @(negedge clk);
        check("R10 mid reset", {1'b0, strb_action, strb_virtual, strb_illegal}, 4'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule